// File: doc/BRIEF.md
# Serial EEPROM Erase and Status Responder

This block is the device side of a three-wire serial EEPROM command path. It is cut down to the two erase commands: single-word erase and whole-array erase. A host drives chip select, a serial clock and a serial data line. The block samples these lines with a free-running system clock and finds each rising edge of the serial clock. It shifts in a start bit, a two-bit opcode and an address field, then runs a self-timed erase on an internal word array. Every other opcode is decoded only far enough to be ignored.

While an erase runs, the block is busy for a fixed number of system clock cycles. It shows this on the serial data-out line, which is presented as a data bit `sdo` and a drive enable `sdo_oe`. When the enable is low, the line is at high impedance, and the pad lives outside the block. The host raises chip select again after a long enough low period to read the status. Data-out reads 0 while the erase is running and 1 once it is done. A start bit followed by chip select going low clears the status.

Erasing is gated by an internal write-enable flag that follows a test input. A backdoor port lets a test environment load and read array words.

Top module: `serial_erase_resp`

## Requirements
- R1: The frame `1`, opcode `11`, then an ADDR_W-bit address sent most significant bit first, sets every bit of the addressed word to 1 and leaves all other words unchanged.
- R2: The frame `1`, opcode `00`, then an address field whose top two bits are `10` (lower bits don't care) sets every word of the array to all ones.
- R3: The erase cycle starts in the system clock cycle that samples the final frame bit on a serial clock rising edge. It then completes with no further serial clock edges.
- R4: Busy lasts exactly BUSY_CYCLES system clocks for a word erase, and max(BUSY_CYCLES, 2^ADDR_W) for an array erase. While status is displayed, `sdo` is 0 during busy and 1 afterwards.
- R5: Status is displayed (`sdo_oe`=1) only when chip select rises after being low for at least CSL_MIN system clocks, and only while an erase result is pending. A shorter low period leaves `sdo_oe` at 0.
- R6: Once the erase is done, a start bit (a 1 on a serial clock rise) followed by chip select going low clears the pending status. The next qualified chip select rise then leaves `sdo_oe` at 0.
- R7: `sdo_oe` is 0 after reset, whenever chip select is low, and while a frame is shifted in with no status pending.
- R8: While busy, start bits and whole frames are ignored: memory is not changed and the pending status is not cleared.
- R9: Chip select going low before the final frame bit aborts decoding: memory is unchanged and no status becomes pending.
- R10: The opcodes `10` and `01`, and opcode `00` with top address bits `00`, `01` or `11`, change no memory and set no status.
- R11: With `erase_unlock` low, erase frames change no memory and set no status.
- R12: A backdoor write (`bd_we`) stores `bd_wdata` at `bd_addr`. `bd_rdata` shows the word at `bd_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, free running |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| erase_unlock | input | 1 | Test hook that sets the internal write-enable flag |
| sdo | output | 1 | Serial data out value (0 busy, 1 ready) |
| sdo_oe | output | 1 | Drive enable for data out; 0 means high impedance |
| bd_we | input | 1 | Backdoor write strobe |
| bd_addr | input | ADDR_W | Backdoor word address |
| bd_wdata | input | WORD_W | Backdoor write data |
| bd_rdata | output | WORD_W | Backdoor read data, registered |

## Verification
The assertions assume that `cs`, `sclk` and `sdi` are synchronous to `clk`, and that each serial clock level is held for at least one system clock. They also assume that backdoor writes never coincide with a running erase. The bench changes every input on the falling edge of `clk` and holds each serial clock phase for a full system clock. It issues backdoor traffic only after data-out has reported ready, so the stimulus stays inside these assumptions. Random frames mix word erases, array erases, foreign opcodes, aborted frames and locked attempts. Directed cases cover the exact busy length, a chip select low period that is too short, and frames sent while busy.

// File: rtl/sera_pkg.sv
`timescale 1ns/1ps
package sera_pkg;

  typedef enum logic {
    ER_WORD = 1'b0,
    ER_ALL  = 1'b1
  } er_mode_t;

  localparam logic [1:0] OPC_ERASE  = 2'b11;
  localparam logic [1:0] OPC_MISC   = 2'b00;
  localparam logic [1:0] MISC_ERALL = 2'b10;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sera_decode.sv
`timescale 1ns/1ps
module sera_decode
  import sera_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              sclk_rise,
  input  logic              sdi,
  input  logic              hold,
  output logic              start_ok,
  output logic              issue,
  output er_mode_t          issue_mode,
  output logic [ADDR_W-1:0] issue_addr
);

  localparam int FRAME = ADDR_W + 2;
  localparam int CW    = $clog2(FRAME + 2);
  localparam logic [CW-1:0] LAST = CW'(FRAME);
  localparam logic [CW-1:0] DONE = CW'(FRAME + 1);

  logic [CW-1:0]     cnt;
  logic [FRAME-2:0]  sh;
  logic [FRAME-1:0]  full;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] adr;
  logic              at_last;

  always_comb begin
    full       = {sh, sdi};
    opc        = full[FRAME-1 -: 2];
    adr        = full[ADDR_W-1:0];
    start_ok   = cs && sclk_rise && (cnt == '0) && sdi && !hold;
    at_last    = cs && sclk_rise && (cnt == LAST);
    issue      = 1'b0;
    issue_mode = ER_WORD;
    issue_addr = adr;
    if (at_last) begin
      if (opc == OPC_ERASE) begin
        issue = 1'b1;
      end else if ((opc == OPC_MISC) && (adr[ADDR_W-1 -: 2] == MISC_ERALL)) begin
        issue      = 1'b1;
        issue_mode = ER_ALL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      sh  <= '0;
    end else if (!cs) begin
      cnt <= '0;
    end else if (sclk_rise) begin
      if (cnt == '0) begin
        if (sdi && !hold) cnt <= CW'(1);
      end else if (cnt != DONE) begin
        sh  <= {sh[FRAME-3:0], sdi};
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R9: a low chip select leaves the decoder waiting for a fresh start bit
  a_r9_abort_clears: assert property (@(posedge clk) disable iff (rst)
    !cs |=> (cnt == '0));

endmodule

// File: rtl/sera_engine.sv
`timescale 1ns/1ps
module sera_engine
  import sera_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int BUSY_CYCLES = 1200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  er_mode_t          go_mode,
  input  logic [ADDR_W-1:0] go_addr,
  output logic              busy,
  output logic              we,
  output logic [ADDR_W-1:0] waddr
);

  localparam int DEPTH       = 1 << ADDR_W;
  localparam int ALL_CYCLES  = max_i(BUSY_CYCLES, DEPTH);
  localparam int TW          = $clog2(ALL_CYCLES + 1);
  localparam logic [TW-1:0] T_WORD = TW'(BUSY_CYCLES - 1);
  localparam logic [TW-1:0] T_ALL  = TW'(ALL_CYCLES - 1);
  localparam logic [ADDR_W:0] DEPTH_W = (ADDR_W + 1)'(DEPTH);

  logic [TW-1:0]     timer;
  er_mode_t          mode;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W:0]   walk;

  always_comb begin
    if (mode == ER_WORD) begin
      we    = busy && (walk == '0);
      waddr = addr_q;
    end else begin
      we    = busy && (walk < DEPTH_W);
      waddr = walk[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      timer  <= '0;
      mode   <= ER_WORD;
      addr_q <= '0;
      walk   <= '0;
    end else if (go && !busy) begin
      busy   <= 1'b1;
      timer  <= (go_mode == ER_ALL) ? T_ALL : T_WORD;
      mode   <= go_mode;
      addr_q <= go_addr;
      walk   <= '0;
    end else if (busy) begin
      if (timer == '0) busy <= 1'b0;
      else             timer <= timer - 1'b1;
      if (we) walk <= walk + 1'b1;
    end
  end

  // R4: busy cannot end while the countdown still has cycles left
  a_r4_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && (timer != '0)) |=> busy);

  // R4: the countdown is spent whenever the engine is idle
  a_r4_idle_timer: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (timer == '0));

  // R2: an array erase has visited every word by the time busy drops
  a_r2_walk_done: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && (mode == ER_ALL)) |-> (walk == DEPTH_W));

endmodule

// File: rtl/sera_status.sv
`timescale 1ns/1ps
module sera_status #(
  parameter int CSL_MIN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic busy,
  input  logic go,
  input  logic start_ok,
  output logic sdo,
  output logic sdo_oe
);

  localparam int LW = $clog2(CSL_MIN + 1);
  localparam logic [LW-1:0] LMIN = LW'(CSL_MIN);

  logic          cs_q;
  logic [LW-1:0] lowcnt;
  logic          armed;
  logic          clr_pend;
  logic          show;
  logic          cs_fall;
  logic          cs_rise;

  assign cs_fall = cs_q && !cs;
  assign cs_rise = !cs_q && cs;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q     <= 1'b0;
      lowcnt   <= '0;
      armed    <= 1'b0;
      clr_pend <= 1'b0;
      show     <= 1'b0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
    end else begin
      cs_q <= cs;
      if (cs)                 lowcnt <= '0;
      else if (lowcnt < LMIN) lowcnt <= lowcnt + 1'b1;

      if (go) begin
        armed    <= 1'b1;
        clr_pend <= 1'b0;
      end else if (cs_fall) begin
        if (clr_pend) armed <= 1'b0;
        clr_pend <= 1'b0;
      end else if (start_ok && armed && !busy) begin
        clr_pend <= 1'b1;
      end

      if (!cs)                                        show <= 1'b0;
      else if (cs_rise && armed && (lowcnt >= LMIN))  show <= 1'b1;

      sdo_oe <= show && cs;
      sdo    <= !busy;
    end
  end

  // R7: data out is released while chip select is low
  a_r7_hiz_cs_low: assert property (@(posedge clk) disable iff (rst)
    !cs |=> !sdo_oe);

  // R5: data out is only driven for a pending erase result
  a_r5_oe_needs_armed: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> $past(armed));

endmodule

// File: rtl/sera_mem.sv
`timescale 1ns/1ps
module sera_mem #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end

endmodule

// File: rtl/serial_erase_resp.sv
`timescale 1ns/1ps
module serial_erase_resp
  import sera_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 10,
  parameter int BUSY_CYCLES = 1200,
  parameter int CSL_MIN     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              erase_unlock,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              bd_we,
  input  logic [ADDR_W-1:0] bd_addr,
  input  logic [WORD_W-1:0] bd_wdata,
  output logic [WORD_W-1:0] bd_rdata
);

  logic              sclk_q;
  logic              unlock_q;
  logic              sclk_rise;
  logic              busy;
  logic              start_ok;
  logic              issue;
  er_mode_t          issue_mode;
  logic [ADDR_W-1:0] issue_addr;
  logic              go;
  logic              eng_we;
  logic [ADDR_W-1:0] eng_waddr;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [WORD_W-1:0] mem_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      unlock_q <= 1'b0;
    end else begin
      sclk_q   <= sclk;
      unlock_q <= erase_unlock;
    end
  end

  assign sclk_rise = sclk && !sclk_q;
  assign go        = issue && unlock_q;

  sera_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .cs(cs), .sclk_rise(sclk_rise), .sdi(sdi),
    .hold(busy), .start_ok(start_ok), .issue(issue),
    .issue_mode(issue_mode), .issue_addr(issue_addr)
  );

  sera_engine #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_eng (
    .clk(clk), .rst(rst), .go(go), .go_mode(issue_mode), .go_addr(issue_addr),
    .busy(busy), .we(eng_we), .waddr(eng_waddr)
  );

  sera_status #(.CSL_MIN(CSL_MIN)) u_sts (
    .clk(clk), .rst(rst), .cs(cs), .busy(busy), .go(go), .start_ok(start_ok),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  always_comb begin
    mem_we    = eng_we || bd_we;
    mem_waddr = eng_we ? eng_waddr : bd_addr;
    mem_wdata = eng_we ? {WORD_W{1'b1}} : bd_wdata;
  end

  sera_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(bd_addr), .rdata(bd_rdata)
  );

  // R8: the decoder never produces a command while an erase is running
  a_r8_no_go_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !go);

endmodule

// File: tb/sim_serial_erase_resp.sv
`timescale 1ns/1ps
module sim_serial_erase_resp;

  localparam int AW    = 6;
  localparam int WW    = 16;
  localparam int BUSY  = 100;
  localparam int CSL   = 32;
  localparam int DEPTH = 1 << AW;
  localparam int NF    = AW + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sclk = 1'b0, sdi = 1'b0, erase_unlock = 1'b0;
  logic sdo, sdo_oe;
  logic bd_we = 1'b0;
  logic [AW-1:0] bd_addr = '0;
  logic [WW-1:0] bd_wdata = '0;
  logic [WW-1:0] bd_rdata;

  int nchk = 0;
  int nerr = 0;
  int shift_bad = 0;
  logic [WW-1:0] mdl [DEPTH];

  always #4 clk = ~clk;

  serial_erase_resp #(.WORD_W(WW), .ADDR_W(AW), .BUSY_CYCLES(BUSY), .CSL_MIN(CSL)) u0 (
    .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .sdi(sdi),
    .erase_unlock(erase_unlock), .sdo(sdo), .sdo_oe(sdo_oe),
    .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata), .bd_rdata(bd_rdata)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] rnd_word();
    logic [WW-1:0] d;
    d = WW'($urandom);
    if (d == '1) d[0] = 1'b0;
    return d;
  endfunction

  function automatic logic [31:0] fr_erase(input int a);
    logic [31:0] v;
    v = '0;
    v[NF-1:0] = {1'b1, 2'b11, AW'(a)};
    return v;
  endfunction

  function automatic logic [31:0] fr_all(input int x);
    logic [31:0] v;
    v = '0;
    v[NF-1:0] = {1'b1, 2'b00, 2'b10, (AW-2)'(x)};
    return v;
  endfunction

  function automatic logic [31:0] fr_bad(input int k, input int x);
    logic [31:0] v;
    logic [1:0] op, md;
    v = '0;
    case (k % 5)
      0: begin op = 2'b10; md = 2'(x); end
      1: begin op = 2'b01; md = 2'(x); end
      2: begin op = 2'b00; md = 2'b00; end
      3: begin op = 2'b00; md = 2'b01; end
      default: begin op = 2'b00; md = 2'b11; end
    endcase
    v[NF-1:0] = {1'b1, op, md, (AW-2)'(x >> 2)};
    return v;
  endfunction

  task automatic bd_write(input int a, input logic [WW-1:0] d);
    bd_we = 1'b1; bd_addr = AW'(a); bd_wdata = d;
    tick(1);
    bd_we = 1'b0;
  endtask

  task automatic preload();
    for (int a = 0; a < DEPTH; a++) begin
      mdl[a] = rnd_word();
      bd_write(a, mdl[a]);
    end
  endtask

  task automatic verify_all(input string req);
    int bad;
    logic [WW-1:0] first_act, first_exp;
    bad = 0; first_act = '0; first_exp = '0;
    for (int a = 0; a < DEPTH; a++) begin
      bd_addr = AW'(a);
      tick(1);
      if (bd_rdata !== mdl[a]) begin
        if (bad == 0) begin first_act = bd_rdata; first_exp = mdl[a]; end
        bad++;
      end
    end
    chk(bad == 0, req, 32'(first_act), 32'(first_exp));
  endtask

  task automatic send_frame(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      tick(1);
      sclk = 1'b1;
      tick(1);
      if (sdo_oe) shift_bad++;
      if (i != 0) sclk = 1'b0;
    end
  endtask

  task automatic begin_frame();
    cs = 1'b0; sclk = 1'b0;
    tick(2);
    cs = 1'b1;
    tick(1);
  endtask

  task automatic end_frame();
    sclk = 1'b0; cs = 1'b0;
    tick(1);
  endtask

  task automatic cycle_status();
    cs = 1'b0; sclk = 1'b0;
    tick(CSL + 3);
    cs = 1'b1;
    tick(4);
  endtask

  task automatic wait_ready(output bit ok);
    cycle_status();
    ok = 1'b0;
    for (int t = 0; t < 400; t++) begin
      if (sdo_oe && sdo) begin ok = 1'b1; break; end
      tick(1);
    end
  endtask

  task automatic clear_status();
    sdi = 1'b1;
    tick(1); sclk = 1'b1;
    tick(1); sclk = 1'b0;
    cycle_status();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    bit ok;
    int bad;
    void'($urandom(32'd20240607));
    tick(5);
    rst = 1'b0;
    tick(2);
    chk(sdo_oe == 1'b0, "R7 reset hi-z", 32'(sdo_oe), 0);

    preload();
    verify_all("R12 backdoor write/read");
    erase_unlock = 1'b1;
    tick(2);

    // R3/R4 exact busy window, no serial clocks after the last bit
    shift_bad = 0;
    begin_frame();
    send_frame(fr_erase(5), NF);
    mdl[5] = '1;
    bad = 0;
    for (int j = 1; j <= BUSY + 5; j++) begin
      tick(1);
      if (j == 1) cs = 1'b0;
      if (j == CSL + 3) begin cs = 1'b1; sclk = 1'b0; end
      if (j >= CSL + 10) begin
        if (!(sdo_oe && (sdo == (j >= BUSY + 1)))) bad++;
      end
    end
    chk(bad == 0, "R3 R4 busy window length", 32'(bad), 0);
    chk(shift_bad == 0, "R7 hi-z while shifting", 32'(shift_bad), 0);

    // R5 low period too short, then long enough
    cs = 1'b0; tick(CSL - 4); cs = 1'b1; tick(4);
    chk(sdo_oe == 1'b0, "R5 short low no status", 32'(sdo_oe), 0);
    cs = 1'b0; tick(CSL + 3); cs = 1'b1; tick(4);
    chk(sdo_oe && sdo, "R5 qualified low shows ready", {sdo_oe, sdo}, 32'h3);
    clear_status();
    chk(sdo_oe == 1'b0, "R6 start bit clears status", 32'(sdo_oe), 0);
    cs = 1'b0;
    verify_all("R1 word erase");

    // R2 array erase
    preload();
    begin_frame();
    send_frame(fr_all(13), NF);
    end_frame();
    for (int a = 0; a < DEPTH; a++) mdl[a] = '1;
    wait_ready(ok);
    chk(ok, "R2 array erase ready", 32'(ok), 1);
    clear_status();
    cs = 1'b0;
    verify_all("R2 array erase contents");

    // R8 frames while busy
    preload();
    shift_bad = 0;
    begin_frame();
    send_frame(fr_erase(10), NF);
    end_frame();
    mdl[10] = '1;
    begin_frame();
    send_frame(fr_erase(20), NF);
    end_frame();
    begin_frame();
    send_frame(32'h1, 1);
    end_frame();
    chk(shift_bad == 0, "R7 hi-z while shifting when busy", 32'(shift_bad), 0);
    wait_ready(ok);
    chk(ok, "R8 status kept across ignored start bit", 32'(ok), 1);
    clear_status();
    cs = 1'b0;
    verify_all("R8 busy frames ignored");

    // R9 abort
    begin_frame();
    send_frame(fr_erase(30) >> 3, NF - 3);
    end_frame();
    cycle_status();
    chk(sdo_oe == 1'b0, "R9 abort no status", 32'(sdo_oe), 0);
    cs = 1'b0;
    verify_all("R9 abort memory unchanged");

    // R10 foreign opcodes
    for (int k = 0; k < 5; k++) begin
      begin_frame();
      send_frame(fr_bad(k, 6 + k), NF);
      end_frame();
    end
    cycle_status();
    chk(sdo_oe == 1'b0, "R10 foreign opcode no status", 32'(sdo_oe), 0);
    cs = 1'b0;
    verify_all("R10 foreign opcode memory unchanged");

    // R11 locked
    erase_unlock = 1'b0;
    tick(2);
    begin_frame();
    send_frame(fr_erase(7), NF);
    end_frame();
    cycle_status();
    chk(sdo_oe == 1'b0, "R11 locked no status", 32'(sdo_oe), 0);
    cs = 1'b0;
    verify_all("R11 locked memory unchanged");
    erase_unlock = 1'b1;
    tick(2);

    // random mix
    for (int it = 0; it < 16; it++) begin
      int op, a;
      op = int'($urandom % 8);
      a  = int'($urandom % DEPTH);
      for (int p = 0; p < 4; p++) begin
        int b;
        b = int'($urandom % DEPTH);
        mdl[b] = rnd_word();
        bd_write(b, mdl[b]);
      end
      if (op == 7) begin erase_unlock = 1'b0; tick(2); end
      begin_frame();
      if (op <= 3 || op == 7) send_frame(fr_erase(a), NF);
      else if (op == 4)       send_frame(fr_all(int'($urandom)), NF);
      else if (op == 5)       send_frame(fr_bad(int'($urandom % 5), int'($urandom)), NF);
      else                    send_frame(fr_erase(a) >> 2, NF - 2);
      end_frame();
      if (op <= 4) begin
        if (op == 4) for (int w = 0; w < DEPTH; w++) mdl[w] = '1;
        else mdl[a] = '1;
        wait_ready(ok);
        chk(ok, "R4 random erase reports ready", 32'(ok), 1);
        clear_status();
      end else begin
        cycle_status();
        chk(sdo_oe == 1'b0, "R9 R10 R11 random ignored no status", 32'(sdo_oe), 0);
      end
      cs = 1'b0;
      erase_unlock = 1'b1;
      tick(2);
      verify_all("R1 R2 random contents");
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule